// File: doc/BRIEF.md
# Skewed-Pitch Tile Transpose Buffer

This block turns a stream of matrix rows into a stream of matrix columns for one square tile of 32 x 32 words, each 32 bits wide. The storage is split into 32 single-port banks, each one word wide. A tile is loaded one row vector per accepted beat. The rows arrive in order and can be counted in groups of eight, so a full tile takes four groups. The tile is then unloaded one column vector per cycle, which makes the output stream the transpose of the input.

Each stored row takes 33 word slots, not 32. Element (i, j) sits at linear slot i*33+j, in bank (i*33+j) mod 32 and at line (i*33+j) div 32. Because 33 and 32 share no factor, a row write and a column read each touch every bank exactly once. Both phases therefore run at one vector per cycle. With a 32-slot pitch, every element of a column would fall in the same bank and a column read would need 32 accesses. The pad costs one word per row: 1056 words of storage in place of 1024.

Tiles at the matrix edge are partial. The row and column counts given at start limit which words are written and which are emitted. The fill phase must finish before the drain phase begins. A one-cycle done pulse closes each phase.

Top module: `tt_transpose_buf`

## Requirements
- R1: After reset, in_ready, out_valid, fill_done and drain_done are all 0.
- R2: A start pulse while idle latches cfg_rows and cfg_cols, each in the range 1..32, and opens the fill phase. During the fill phase in_ready is 1. Each cycle with in_valid and in_ready both high accepts one row: in_row bits [32j+31:32j] carry word j. Rows are taken in order, starting at row 0.
- R3: In the cycle after the last of cfg_rows rows is accepted, fill_done is 1 for exactly one cycle and in_ready is 0.
- R4: In the drain phase, out_idx gives the column number j. Bits [32i+31:32i] of out_col equal word j of input row i. Columns are emitted in order from 0 to cfg_cols-1.
- R5: The first column is valid in the cycle after fill_done. While out_ready stays high, a new column is presented every cycle with no gap.
- R6: While out_valid is 1 and out_ready is 0, out_col, out_idx and out_mask do not change.
- R7: Bit i of out_mask is 1 exactly when i < cfg_rows. Lanes at or above cfg_rows read as zero. No column at or above cfg_cols is emitted.
- R8: In the cycle after the last column is accepted, drain_done is 1 for exactly one cycle, out_valid is 0, and the block is idle again.
- R9: A start pulse during the fill or drain phase is ignored, and so is any cfg value shown with it.
- R10: in_valid and in_row have no effect outside the fill phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a tile (acted on only when idle) |
| cfg_rows | input | 6 | Valid rows in this tile, 1..32 |
| cfg_cols | input | 6 | Valid columns in this tile, 1..32 |
| in_valid | input | 1 | Row beat offered |
| in_ready | output | 1 | Row beat accepted this cycle if in_valid |
| in_row | input | 1024 | Row vector, word j at bits [32j+31:32j] |
| out_valid | output | 1 | Column vector presented |
| out_ready | input | 1 | Consumer takes the column this cycle |
| out_col | output | 1024 | Column vector, row i at bits [32i+31:32i] |
| out_mask | output | 32 | Lane i holds a real element |
| out_idx | output | 5 | Column number of out_col |
| fill_done | output | 1 | One-cycle pulse after the last row |
| drain_done | output | 1 | One-cycle pulse after the last column |

## Verification
The assertions take for granted that cfg_rows and cfg_cols lie between 1 and 32 whenever start is raised in the idle state. They also take for granted that out_ready is a plain level driven by the consumer. The properties that count mask bits and bound the column index copy the configuration on an idle start, so they depend on that range. The bench only ever picks counts inside 1..32. It drives start outside the idle state solely with in-range values, so the ignore rule is tested without breaking the range assumption.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } tt_state_e;
endpackage

// File: rtl/tt_bank.sv
module tt_bank #(
    parameter int W     = 32,
    parameter int DEPTH = 33,
    localparam int LW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [LW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Read data is registered and held until the next read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/tt_fill_route.sv
module tt_fill_route #(
    parameter int TILE  = 32,
    parameter int W     = 32,
    parameter int PITCH = 33,
    localparam int IW   = $clog2(TILE),
    localparam int CW   = $clog2(TILE + 1),
    localparam int LW   = $clog2(PITCH)
) (
    input  logic               wr,
    input  logic [IW-1:0]      row_idx,
    input  logic [CW-1:0]      cols,
    input  logic [TILE*W-1:0]  row_data,
    output logic [TILE-1:0]    bank_we,
    output logic [TILE*LW-1:0] bank_line,
    output logic [TILE*W-1:0]  bank_wdata
);
    // Bank b takes the word whose slot row_idx*PITCH+j falls in b.
    for (genvar b = 0; b < TILE; b++) begin : g_bank
        always_comb begin
            int base, rot, jsel, slot;
            base = int'(row_idx) * PITCH;
            rot  = base % TILE;
            jsel = (b + TILE - rot) % TILE;
            slot = base + jsel;
            bank_we[b]                = wr && (jsel < int'(cols));
            bank_line[b*LW +: LW]     = LW'(slot / TILE);
            bank_wdata[b*W +: W]      = row_data[jsel*W +: W];
        end
    end
endmodule

// File: rtl/tt_drain_route.sv
module tt_drain_route #(
    parameter int TILE  = 32,
    parameter int W     = 32,
    parameter int PITCH = 33,
    localparam int IW   = $clog2(TILE),
    localparam int CW   = $clog2(TILE + 1),
    localparam int LW   = $clog2(PITCH),
    localparam int SKEW = PITCH % TILE
) (
    input  logic               rd,
    input  logic [IW-1:0]      rd_col,
    output logic [TILE-1:0]    bank_re,
    output logic [TILE*LW-1:0] bank_line,
    input  logic [IW-1:0]      ret_col,
    input  logic [CW-1:0]      rows,
    input  logic [TILE*W-1:0]  bank_rdata,
    output logic [TILE*W-1:0]  col_data,
    output logic [TILE-1:0]    col_mask
);
    // Request side: bank b holds the row i with (i*SKEW + col) mod TILE == b.
    for (genvar b = 0; b < TILE; b++) begin : g_req
        always_comb begin
            int isel, slot;
            isel = ((b + TILE - int'(rd_col)) % TILE) * SKEW % TILE;
            slot = isel * PITCH + int'(rd_col);
            bank_re[b]            = rd;
            bank_line[b*LW +: LW] = LW'(slot / TILE);
        end
    end

    // Return side: lane i picks the bank where element (i, ret_col) sits.
    for (genvar i = 0; i < TILE; i++) begin : g_ret
        always_comb begin
            int src;
            src         = (i * PITCH + int'(ret_col)) % TILE;
            col_mask[i] = (i < int'(rows));
            col_data[i*W +: W] = col_mask[i] ? bank_rdata[src*W +: W] : '0;
        end
    end
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
    import tt_pkg::*;
#(
    parameter int TILE = 32,
    localparam int IW  = $clog2(TILE),
    localparam int CW  = $clog2(TILE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cfg_rows,
    input  logic [CW-1:0] cfg_cols,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          row_wr,
    output logic [IW-1:0] row_idx,
    output logic [CW-1:0] cols,
    output logic [CW-1:0] rows,
    output logic          rd_en,
    output logic [IW-1:0] rd_col,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [IW-1:0] out_idx,
    output logic          fill_done,
    output logic          drain_done
);
    tt_state_e     state_q, state_d;
    logic [CW-1:0] rows_q, cols_q, row_cnt_q, rd_cnt_q;
    logic          ov_q, fdone_q, ddone_q;
    logic [IW-1:0] oidx_q;
    logic          accept, last_row, pop, last_pop, slot_free;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        rd_en     = 1'b0;
        pop       = ov_q && out_ready;
        last_pop  = pop && (CW'(oidx_q) == CW'(cols_q - 1'b1));
        last_row  = (row_cnt_q == CW'(rows_q - 1'b1));
        slot_free = !ov_q || out_ready;
        accept    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_FILL;
            end
            ST_FILL: begin
                in_ready = 1'b1;
                accept   = in_valid;
                if (accept && last_row) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                rd_en = (rd_cnt_q < cols_q) && slot_free;
                if (last_pop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q    <= CW'(1);
            cols_q    <= CW'(1);
            row_cnt_q <= '0;
            rd_cnt_q  <= '0;
            ov_q      <= 1'b0;
            oidx_q    <= '0;
            fdone_q   <= 1'b0;
            ddone_q   <= 1'b0;
        end else begin
            fdone_q <= accept && last_row;
            ddone_q <= last_pop;
            if (state_q == ST_IDLE && start) begin
                rows_q    <= cfg_rows;
                cols_q    <= cfg_cols;
                row_cnt_q <= '0;
                rd_cnt_q  <= '0;
            end
            if (accept) row_cnt_q <= row_cnt_q + 1'b1;
            if (rd_en) begin
                rd_cnt_q <= rd_cnt_q + 1'b1;
                oidx_q   <= rd_cnt_q[IW-1:0];
                ov_q     <= 1'b1;
            end else if (pop) begin
                ov_q <= 1'b0;
            end
        end
    end

    assign row_wr     = accept;
    assign row_idx    = row_cnt_q[IW-1:0];
    assign rd_col     = rd_cnt_q[IW-1:0];
    assign cols       = cols_q;
    assign rows       = rows_q;
    assign out_valid  = ov_q;
    assign out_idx    = oidx_q;
    assign fill_done  = fdone_q;
    assign drain_done = ddone_q;
endmodule

// File: rtl/tt_transpose_buf.sv
module tt_transpose_buf #(
    parameter int TILE  = 32,
    parameter int W     = 32,
    localparam int PITCH = TILE + 1,
    localparam int IW    = $clog2(TILE),
    localparam int CW    = $clog2(TILE + 1),
    localparam int LW    = $clog2(PITCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW-1:0]     cfg_rows,
    input  logic [CW-1:0]     cfg_cols,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TILE*W-1:0] in_row,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TILE*W-1:0] out_col,
    output logic [TILE-1:0]   out_mask,
    output logic [IW-1:0]     out_idx,
    output logic              fill_done,
    output logic              drain_done
);
    logic               row_wr, rd_en;
    logic [IW-1:0]      row_idx, rd_col;
    logic [CW-1:0]      cols, rows;
    logic [TILE-1:0]    f_we, d_re;
    logic [TILE*LW-1:0] f_line, d_line;
    logic [TILE*W-1:0]  f_wdata, b_rdata;

    tt_ctrl #(.TILE(TILE)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
        .in_valid(in_valid), .in_ready(in_ready),
        .row_wr(row_wr), .row_idx(row_idx), .cols(cols), .rows(rows),
        .rd_en(rd_en), .rd_col(rd_col),
        .out_ready(out_ready), .out_valid(out_valid), .out_idx(out_idx),
        .fill_done(fill_done), .drain_done(drain_done)
    );

    tt_fill_route #(.TILE(TILE), .W(W), .PITCH(PITCH)) fill_i (
        .wr(row_wr), .row_idx(row_idx), .cols(cols), .row_data(in_row),
        .bank_we(f_we), .bank_line(f_line), .bank_wdata(f_wdata)
    );

    tt_drain_route #(.TILE(TILE), .W(W), .PITCH(PITCH)) drain_i (
        .rd(rd_en), .rd_col(rd_col), .bank_re(d_re), .bank_line(d_line),
        .ret_col(out_idx), .rows(rows), .bank_rdata(b_rdata),
        .col_data(out_col), .col_mask(out_mask)
    );

    // Fill and drain never overlap, so one port per bank is enough.
    for (genvar b = 0; b < TILE; b++) begin : g_mem
        logic [LW-1:0] addr;
        assign addr = f_we[b] ? f_line[b*LW +: LW] : d_line[b*LW +: LW];
        tt_bank #(.W(W), .DEPTH(PITCH)) bank_i (
            .clk(clk), .en(f_we[b] | d_re[b]), .we(f_we[b]),
            .addr(addr), .wdata(f_wdata[b*W +: W]),
            .rdata(b_rdata[b*W +: W])
        );
    end
endmodule

// File: rtl/tt_transpose_buf_chk.sv
module tt_transpose_buf_chk #(
    parameter int TILE = 32,
    parameter int W    = 32,
    localparam int IW  = $clog2(TILE),
    localparam int CW  = $clog2(TILE + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CW-1:0]     cfg_rows,
    input logic [CW-1:0]     cfg_cols,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [TILE*W-1:0] out_col,
    input logic [TILE-1:0]   out_mask,
    input logic [IW-1:0]     out_idx,
    input logic              fill_done,
    input logic              drain_done
);
    logic          idle_q;
    logic [CW-1:0] lat_rows, lat_cols;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q   <= 1'b1;
            lat_rows <= CW'(TILE);
            lat_cols <= CW'(TILE);
        end else if (idle_q && start) begin
            idle_q   <= 1'b0;
            lat_rows <= cfg_rows;
            lat_cols <= cfg_cols;
        end else if (drain_done) begin
            idle_q <= 1'b1;
        end
    end

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid)); // R2
    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done); // R3
    AST_FILL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> !in_ready); // R3
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid || out_idx == IW'($past(out_idx) + 1'b1))); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_col) && $stable(out_idx) && $stable(out_mask))); // R6
    AST_MASK_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_mask) == int'(lat_rows))); // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (CW'(out_idx) < lat_cols)); // R7
    AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> (!out_valid && !in_ready)); // R8
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_done, drain_done})); // R8
endmodule

bind tt_transpose_buf tt_transpose_buf_chk #(.TILE(TILE), .W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_col(out_col), .out_mask(out_mask), .out_idx(out_idx),
    .fill_done(fill_done), .drain_done(drain_done)
);

// File: tb/tt_transpose_buf_tb_top.sv
module tt_transpose_buf_tb_top;
    localparam int TILE = 32;
    localparam int W    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [5:0]        cfg_rows = 6'd0, cfg_cols = 6'd0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [TILE*W-1:0] in_row = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [TILE*W-1:0] out_col;
    logic [TILE-1:0]   out_mask;
    logic [4:0]        out_idx;
    logic              fill_done, drain_done;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    tt_transpose_buf #(.TILE(TILE), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
        .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col),
        .out_mask(out_mask), .out_idx(out_idx),
        .fill_done(fill_done), .drain_done(drain_done)
    );

    function automatic logic [31:0] elem(int t, int i, int j);
        return {8'(t), 8'(i), 8'(j), 8'h5A};
    endfunction

    function automatic logic [TILE*W-1:0] make_row(int t, int i);
        logic [TILE*W-1:0] v;
        for (int j = 0; j < TILE; j++) v[j*W +: W] = elem(t, i, j);
        return v;
    endfunction

    function automatic logic [TILE*W-1:0] make_col(int t, int j, int rows);
        logic [TILE*W-1:0] v;
        for (int i = 0; i < TILE; i++) v[i*W +: W] = (i < rows) ? elem(t, i, j) : 32'h0;
        return v;
    endfunction

    task automatic check(string req, logic [TILE*W-1:0] act, logic [TILE*W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic begin_tile(int rows, int cols);
        @(negedge clk);
        start = 1'b1; cfg_rows = 6'(rows); cfg_cols = 6'(cols);
        @(negedge clk);
        start = 1'b0;
        check("R2 in_ready in fill", TILE*W'(in_ready), TILE*W'(1));
    endtask

    // gaps: hold in_valid low on some beats; disturb: raise start mid-fill
    task automatic fill_tile(int t, int rows, bit gaps, bit disturb);
        int i = 0;
        int k = 0;
        while (i < rows) begin
            @(negedge clk);
            if (i > 0) check("R3 no early fill_done", TILE*W'(fill_done), '0);
            in_valid = !(gaps && (k % 3 == 1));
            in_row   = make_row(t, i);
            start    = disturb && (i == 4);
            cfg_rows = disturb ? 6'd3 : cfg_rows;
            cfg_cols = disturb ? 6'd2 : cfg_cols;
            if (in_valid && in_ready) i++;
            k++;
        end
        @(negedge clk);
        in_valid = 1'b0; start = 1'b0;
        check("R3 fill_done pulse", TILE*W'(fill_done), TILE*W'(1));
        check("R3 in_ready closed", TILE*W'(in_ready), '0);
    endtask

    // stall: out_ready low on some cycles; junk: drive in_valid during drain
    task automatic drain_tile(int t, int rows, int cols, bit stall, bit junk, bit disturb);
        int j = 0;
        int c = 0;
        bit held = 0;
        logic [TILE*W-1:0] prev_col;
        logic [4:0] prev_idx;
        logic [TILE-1:0] exp_mask;
        exp_mask = TILE'((33'd1 << rows) - 1);
        while (j < cols) begin
            @(negedge clk);
            if (junk) begin in_valid = 1'b1; in_row = {TILE{32'hDEAD_BEEF}}; end
            start = disturb && (c == 2);
            if (c == 0) check("R5 first column follows fill_done", TILE*W'(out_valid), TILE*W'(1));
            if (held) begin
                check("R6 data held", out_col, prev_col);
                check("R6 idx held", TILE*W'(out_idx), TILE*W'(prev_idx));
            end
            out_ready = !(stall && (c % 4 == 2 || c % 4 == 3));
            if (!stall && !out_valid)
                check("R5 full rate", TILE*W'(out_valid), TILE*W'(1));
            if (out_valid) begin
                check("R4 column index", TILE*W'(out_idx), TILE*W'(j));
                check("R4 R7 column data", out_col, make_col(t, j, rows));
                check("R7 lane mask", TILE*W'(out_mask), TILE*W'(exp_mask));
                prev_col = out_col; prev_idx = out_idx;
                held = !out_ready;
                if (out_ready) j++;
            end
            c++;
            if (c > 2000) break;
        end
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b0; start = 1'b0;
        check("R8 drain_done pulse", TILE*W'(drain_done), TILE*W'(1));
        check("R8 R7 no extra column", TILE*W'(out_valid), '0);
        @(negedge clk);
        check("R8 pulse ends", TILE*W'(drain_done), '0);
        check("R8 idle no in_ready", TILE*W'(in_ready), '0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 in_ready", TILE*W'(in_ready), '0);
        check("R1 out_valid", TILE*W'(out_valid), '0);
        check("R1 done pulses", TILE*W'({fill_done, drain_done}), '0);
    endtask

    task automatic test_full();
        begin_tile(32, 32);
        fill_tile(1, 32, 0, 0);
        drain_tile(1, 32, 32, 0, 0, 0);
    endtask

    task automatic test_stalls();
        begin_tile(32, 32);
        fill_tile(2, 32, 1, 0);
        drain_tile(2, 32, 32, 1, 0, 0);
    endtask

    task automatic test_edge();
        begin_tile(5, 3);
        fill_tile(3, 5, 1, 0);
        drain_tile(3, 5, 3, 1, 0, 0);
        begin_tile(1, 32);
        fill_tile(4, 1, 0, 0);
        drain_tile(4, 1, 32, 0, 0, 0);
        begin_tile(32, 1);
        fill_tile(5, 32, 0, 0);
        drain_tile(5, 32, 1, 0, 0, 0);
    endtask

    task automatic test_ignore();
        // R9 start mid-phase ignored, R10 in_valid outside fill ignored
        begin_tile(9, 20);
        fill_tile(6, 9, 0, 1);
        drain_tile(6, 9, 20, 1, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_full();
        test_stalls();
        test_edge();
        test_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule